// File: doc/BRIEF.md
# Single-Frame Transmit DMA Channel

This block moves one frame at a time from system memory into the transmit byte FIFO of an Ethernet MAC. Software loads a buffer address and the frame length minus one into two registers. It then writes a control word that sets the go bit and the frame marker bits. The channel reads memory as 32-bit words, one request at a time. It unpacks each word least significant byte first and presents the bytes on a byte stream with valid/ready flow control and first/last markers.

The buffer may start at any byte address. Leading bytes of the first word and trailing bytes of the last word are dropped. When the last byte has been accepted, the go bit falls back to 0, which tells software the channel is ready. A status word then records how many bytes went out, and an interrupt line stays high until software acknowledges it by writing the control register. A reset bit in the control register aborts a frame in flight. An abort posts a status word with an error flag, and any memory response still outstanding at that point is discarded. Two per-frame sideband flags, suppress padding and suppress CRC, are captured at start and passed on to the MAC.

Top module: `txdma_chan`

## Requirements
- R1: Offset 0x00 holds the 32-bit buffer byte address and offset 0x04 holds the length minus one in its low 16 bits; upper written bits of 0x04 read back as 0, and writes to either register while a frame is busy leave them unchanged.
- R2: A write to offset 0x0C with bit 0 set and bit 24 clear, while idle, starts a frame; bit 0 of 0x0C reads 1 from the next cycle until the frame ends, then reads 0.
- R3: The stream carries exactly length+1 bytes, namely the memory bytes at addresses base, base+1, and so on; within a memory word, address offset k is data bits 8k+7..8k. Unused leading and trailing word bytes never appear.
- R4: tx_first accompanies the first byte only when bit 2 was set in the start write, and tx_last accompanies the final byte only when bit 3 was set; neither marks any other byte.
- R5: While tx_valid is high and tx_ready is low, tx_valid, tx_data, tx_first and tx_last hold steady, and no byte is lost.
- R6: Memory read requests are word aligned, start at the word holding the base address, rise by 4 each time and number exactly the words the frame spans. At most one request is outstanding.
- R7: At frame end, bit 18 of 0x0C reads 1, and the status word at 0x10 holds the byte count in bits 16:0 with error bit 31 clear. irq_done is high exactly while bit 18 is set.
- R8: Any write to 0x0C clears bit 18 and lowers irq_done; a write with bit 0 clear while idle starts nothing.
- R9: A write with bit 24 set during a frame stops the stream and clears bit 0. It posts a status word with bit 31 set and the count of bytes already accepted. A later frame runs correctly. Bit 24 written while idle posts no status.
- R10: Bits 8 and 9 of the start write drive tx_pad_off and tx_crc_off for the frame and read back in 0x0C.
- R11: Bit 16 of 0x0C reads 1 while a fetched word waits to be streamed, and bit 17 reads its complement.
- R12: After reset, 0x0C reads 0x00020000, 0x10 reads 0, irq_done is low, and neither the stream nor the memory port is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_first | output | 1 | First byte of frame marker |
| tx_last | output | 1 | Last byte of frame marker |
| tx_pad_off | output | 1 | Sideband: padding suppressed for this frame |
| tx_crc_off | output | 1 | Sideband: CRC suppressed for this frame |
| irq_done | output | 1 | Completion status waiting for acknowledgement |

## Verification
The embedded assertions watch, on every cycle, that a stalled byte holds steady, that a marker appears at most once per frame, and that the stream goes quiet after its final byte. They also check that memory responses arrive only against an outstanding request and that addresses stay word aligned. On the register side, they check that a start sets busy and clears the pending status, and that both completion and abort post status and clear busy. Other behaviour shows only across a whole scenario, so the bench checks it: the exact byte content and count for odd start lanes and lengths, the number and order of word requests, and marker placement with the start or end bit missing. The bench scenarios also cover the byte count recorded on abort, the guard against register updates while busy, and correct operation of a frame that follows an abort.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  // Register byte offsets (software contract)
  localparam logic [7:0] OFS_BUF  = 8'h00;
  localparam logic [7:0] OFS_LEN  = 8'h04;
  localparam logic [7:0] OFS_CTRL = 8'h0C;
  localparam logic [7:0] OFS_STAT = 8'h10;

  // Control register bit positions
  localparam int BIT_GO    = 0;
  localparam int BIT_SOF   = 2;
  localparam int BIT_EOF   = 3;
  localparam int BIT_NOPAD = 8;
  localparam int BIT_NOCRC = 9;
  localparam int BIT_FULL  = 16;
  localparam int BIT_EMPTY = 17;
  localparam int BIT_AVAIL = 18;
  localparam int BIT_RST   = 24;

  // Status word error flag
  localparam int BIT_ERR = 31;

  typedef struct packed {
    logic sof;
    logic eof;
    logic nopad;
    logic nocrc;
  } frame_opts_t;

  // Number of 32-bit words touched by a frame starting at byte lane lane0
  function automatic logic [31:0] span_words(input logic [1:0] lane0,
                                             input logic [31:0] lenm1);
    logic [31:0] last_ofs;
    last_ofs = {30'd0, lane0} + lenm1;
    return {2'b00, last_ofs[31:2]} + 32'd1;
  endfunction

  // Byte at a lane of a little-endian word
  function automatic logic [7:0] pick_byte(input logic [31:0] w,
                                           input logic [1:0] lane);
    return w[{lane, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] status_word(input logic err,
                                              input logic [31:0] cnt);
    logic [31:0] s;
    s = cnt;
    s[BIT_ERR] = err;
    return s;
  endfunction

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs import txdma_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              hold_full,
  input  logic              unpack_done,
  input  logic [LEN_W:0]    bytes_done,
  output logic              start_pulse,
  output logic              abort_pulse,
  output logic [31:0]       base_addr,
  output logic [LEN_W-1:0]  len_m1,
  output frame_opts_t       opts,
  output logic              irq
);

  logic        busy_q;
  logic        avail_q;
  logic [31:0] status_q;
  logic [31:0] ctrl_view;

  logic wr_buf, wr_len, wr_ctrl;
  assign wr_buf  = reg_wr && (reg_addr == ADDR_W'(OFS_BUF));
  assign wr_len  = reg_wr && (reg_addr == ADDR_W'(OFS_LEN));
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));

  assign start_pulse = wr_ctrl && reg_wdata[BIT_GO] && !reg_wdata[BIT_RST] && !busy_q;
  assign abort_pulse = wr_ctrl && reg_wdata[BIT_RST] && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      avail_q   <= 1'b0;
      status_q  <= '0;
      base_addr <= '0;
      len_m1    <= '0;
      opts      <= '0;
    end else begin
      if (wr_buf && !busy_q) base_addr <= reg_wdata;
      if (wr_len && !busy_q) len_m1    <= reg_wdata[LEN_W-1:0];
      if (wr_ctrl) avail_q <= 1'b0;
      if (start_pulse) begin
        busy_q     <= 1'b1;
        opts.sof   <= reg_wdata[BIT_SOF];
        opts.eof   <= reg_wdata[BIT_EOF];
        opts.nopad <= reg_wdata[BIT_NOPAD];
        opts.nocrc <= reg_wdata[BIT_NOCRC];
      end
      if (abort_pulse) begin
        busy_q   <= 1'b0;
        avail_q  <= 1'b1;
        status_q <= status_word(1'b1, 32'(bytes_done));
      end else if (unpack_done) begin
        busy_q   <= 1'b0;
        avail_q  <= 1'b1;
        status_q <= status_word(1'b0, 32'(bytes_done));
      end
    end
  end

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[BIT_GO]    = busy_q;
    ctrl_view[BIT_SOF]   = opts.sof;
    ctrl_view[BIT_EOF]   = opts.eof;
    ctrl_view[BIT_NOPAD] = opts.nopad;
    ctrl_view[BIT_NOCRC] = opts.nocrc;
    ctrl_view[BIT_FULL]  = hold_full;
    ctrl_view[BIT_EMPTY] = !hold_full;
    ctrl_view[BIT_AVAIL] = avail_q;
  end

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_BUF))       reg_rdata = base_addr;
    else if (reg_addr == ADDR_W'(OFS_LEN))  reg_rdata = 32'(len_m1);
    else if (reg_addr == ADDR_W'(OFS_CTRL)) reg_rdata = ctrl_view;
    else if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = status_q;
    else                                    reg_rdata = '0;
  end

  assign irq = avail_q;

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy_q && !avail_q);

  assert_done_posts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    unpack_done && !abort_pulse |=> avail_q && !busy_q && !status_q[BIT_ERR]);

  assert_abort_posts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> avail_q && !busy_q && status_q[BIT_ERR]);

endmodule

// File: rtl/txdma_fetch.sv
module txdma_fetch import txdma_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             finish,
  input  logic [31:0]      base_addr,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             hold_full,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             push,
  output logic [31:0]      push_data
);

  logic        active_q;
  logic        outstanding_q;
  logic        discard_q;
  logic [31:0] next_addr_q;
  logic [31:0] words_left_q;
  logic        req_hs;

  assign mem_req_valid = active_q && !outstanding_q && !hold_full && (words_left_q != '0);
  assign mem_req_addr  = next_addr_q;
  assign req_hs        = mem_req_valid && mem_req_ready;
  assign push          = mem_rsp_valid && outstanding_q && !discard_q && active_q;
  assign push_data     = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q      <= 1'b0;
      outstanding_q <= 1'b0;
      discard_q     <= 1'b0;
      next_addr_q   <= '0;
      words_left_q  <= '0;
    end else begin
      if (req_hs) begin
        outstanding_q <= 1'b1;
        next_addr_q   <= next_addr_q + 32'd4;
        words_left_q  <= words_left_q - 32'd1;
      end
      if (mem_rsp_valid) begin
        outstanding_q <= 1'b0;
        discard_q     <= 1'b0;
      end
      if (start) begin
        active_q     <= 1'b1;
        next_addr_q  <= {base_addr[31:2], 2'b00};
        words_left_q <= span_words(base_addr[1:0], 32'(len_m1));
      end else if (abort) begin
        active_q     <= 1'b0;
        words_left_q <= '0;
        discard_q    <= (outstanding_q && !mem_rsp_valid) || req_hs;
      end else if (finish) begin
        active_q <= 1'b0;
      end
    end
  end

  assert_word_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_rsp_expected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> outstanding_q);

endmodule

// File: rtl/txdma_unpack.sv
module txdma_unpack import txdma_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [1:0]       base_lane,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             sof,
  input  logic             eof,
  input  logic             push,
  input  logic [31:0]      push_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_first,
  output logic             tx_last,
  output logic             hold_full,
  output logic             done,
  output logic [LEN_W:0]   bytes_done
);

  logic             run_q;
  logic             hold_q;
  logic [31:0]      word_q;
  logic [1:0]       lane_q;
  logic [LEN_W-1:0] left_q;
  logic             first_q;
  logic             eof_q;
  logic [LEN_W:0]   sent_q;
  logic             byte_hs;
  logic             final_byte;

  assign tx_valid   = run_q && hold_q;
  assign tx_data    = pick_byte(word_q, lane_q);
  assign final_byte = (left_q == '0);
  assign tx_first   = tx_valid && first_q;
  assign tx_last    = tx_valid && eof_q && final_byte;
  assign byte_hs    = tx_valid && tx_ready;
  assign done       = byte_hs && final_byte;
  assign hold_full  = hold_q;
  assign bytes_done = sent_q + {{LEN_W{1'b0}}, byte_hs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hold_q  <= 1'b0;
      word_q  <= '0;
      lane_q  <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
      eof_q   <= 1'b0;
      sent_q  <= '0;
    end else if (start) begin
      run_q   <= 1'b1;
      hold_q  <= 1'b0;
      lane_q  <= base_lane;
      left_q  <= len_m1;
      first_q <= sof;
      eof_q   <= eof;
      sent_q  <= '0;
    end else if (abort) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (push) begin
        hold_q <= 1'b1;
        word_q <= push_data;
      end
      if (byte_hs) begin
        sent_q  <= sent_q + 1'b1;
        first_q <= 1'b0;
        if (final_byte) begin
          run_q  <= 1'b0;
          hold_q <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
          lane_q <= lane_q + 2'd1;
          if (lane_q == 2'd3) hold_q <= 1'b0;
        end
      end
    end
  end

  assert_stream_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !abort |=>
      tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last));

  assert_first_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_hs |=> !tx_first);

  assert_final_byte_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !tx_valid);

endmodule

// File: rtl/txdma_chan.sv
module txdma_chan import txdma_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last,
  output logic              tx_pad_off,
  output logic              tx_crc_off,
  output logic              irq_done
);

  logic             start_pulse;
  logic             abort_pulse;
  logic             unpack_done;
  logic             hold_full;
  logic [LEN_W:0]   bytes_done;
  logic [31:0]      base_addr;
  logic [LEN_W-1:0] len_m1;
  frame_opts_t      opts;
  logic             push;
  logic [31:0]      push_data;

  txdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .hold_full   (hold_full),
    .unpack_done (unpack_done),
    .bytes_done  (bytes_done),
    .start_pulse (start_pulse),
    .abort_pulse (abort_pulse),
    .base_addr   (base_addr),
    .len_m1      (len_m1),
    .opts        (opts),
    .irq         (irq_done)
  );

  txdma_fetch #(.LEN_W(LEN_W)) fetch_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_pulse),
    .abort         (abort_pulse),
    .finish        (unpack_done),
    .base_addr     (base_addr),
    .len_m1        (len_m1),
    .hold_full     (hold_full),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .push          (push),
    .push_data     (push_data)
  );

  txdma_unpack #(.LEN_W(LEN_W)) unpack_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_pulse),
    .abort      (abort_pulse),
    .base_lane  (base_addr[1:0]),
    .len_m1     (len_m1),
    .sof        (reg_wdata[BIT_SOF]),
    .eof        (reg_wdata[BIT_EOF]),
    .push       (push),
    .push_data  (push_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_first   (tx_first),
    .tx_last    (tx_last),
    .hold_full  (hold_full),
    .done       (unpack_done),
    .bytes_done (bytes_done)
  );

  assign tx_pad_off = opts.nopad;
  assign tx_crc_off = opts.nocrc;

endmodule

// File: tb/txdma_chan_tb_top.sv
`timescale 1ns/1ps
module txdma_chan_tb_top;

  localparam logic [4:0] A_BUF  = 5'h00;
  localparam logic [4:0] A_LEN  = 5'h04;
  localparam logic [4:0] A_CTRL = 5'h0C;
  localparam logic [4:0] A_STAT = 5'h10;

  // {base[31:0], lenm1[15:0], sof, eof, stall, nopad}
  localparam int NVEC = 8;
  localparam logic [51:0] VEC [NVEC] = '{
    {32'h0000_0100, 16'd0,  1'b1, 1'b1, 1'b0, 1'b0},
    {32'h0000_0101, 16'd5,  1'b1, 1'b1, 1'b0, 1'b0},
    {32'h0000_0203, 16'd0,  1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_0300, 16'd7,  1'b1, 1'b1, 1'b1, 1'b1},
    {32'h0000_0402, 16'd12, 1'b1, 1'b1, 1'b1, 1'b0},
    {32'h0000_0501, 16'd2,  1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_0600, 16'd4,  1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0000_0703, 16'd20, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        tx_first, tx_last, tx_pad_off, tx_crc_off, irq_done;

  int checks = 0;
  int errors = 0;

  txdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_first(tx_first), .tx_last(tx_last),
    .tx_pad_off(tx_pad_off), .tx_crc_off(tx_crc_off), .irq_done(irq_done)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
  endfunction

  // Bench-side models: memory, byte sink, monitors
  int          cyc = 0;
  int          ready_budget = -1;
  logic        stall_mode = 1'b0;
  logic        rsp_pending = 1'b0;
  logic [31:0] rsp_addr = '0;
  logic [31:0] exp_req = '0;
  int          req_n = 0;
  int          req_bad = 0;
  int          mon_n = 0;
  int          hold_viol = 0;
  logic [7:0]  mon_data [0:255];
  logic        mon_first [0:255];
  logic        mon_last [0:255];
  logic        prev_wait = 1'b0;
  logic [7:0]  prev_data = '0;
  logic        prev_first = 1'b0;
  logic        prev_last = 1'b0;

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (rsp_pending) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(rsp_addr);
      rsp_pending   = 1'b0;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      rsp_pending = 1'b1;
      rsp_addr    = mem_req_addr;
      if (mem_req_addr != exp_req) req_bad++;
      exp_req = exp_req + 32'd4;
      req_n++;
    end
    if (prev_wait) begin
      if (!tx_valid || tx_data != prev_data || tx_first != prev_first || tx_last != prev_last)
        hold_viol++;
    end
    tx_ready = (ready_budget != 0) && (!stall_mode || (cyc % 3 != 1));
    if (rst_n && tx_valid && tx_ready) begin
      if (mon_n < 256) begin
        mon_data[mon_n]  = tx_data;
        mon_first[mon_n] = tx_first;
        mon_last[mon_n]  = tx_last;
      end
      mon_n++;
      if (ready_budget > 0) ready_budget--;
    end
    prev_wait  = tx_valid && !tx_ready;
    prev_data  = tx_data;
    prev_first = tx_first;
    prev_last  = tx_last;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      if (irq_done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic start_frame(input logic [31:0] base, input logic [15:0] lenm1,
                             input logic sof, input logic eof, input logic nopad);
    mon_n = 0; hold_viol = 0; req_n = 0; req_bad = 0;
    exp_req = {base[31:2], 2'b00};
    reg_write(A_BUF, base);
    reg_write(A_LEN, 32'(lenm1));
    reg_write(A_CTRL, (32'd1) | (32'(sof) << 2) | (32'(eof) << 3) |
                      (32'(nopad) << 8) | (32'(!nopad) << 9));
  endtask

  task automatic run_frame(input logic [51:0] v);
    logic [31:0] base, r;
    logic [15:0] lenm1;
    logic sof, eof, stall, nopad;
    bit seen;
    int nbytes, bad_data, bad_mark, exp_words;
    base = v[51:20]; lenm1 = v[19:4]; sof = v[3]; eof = v[2]; stall = v[1]; nopad = v[0];
    ready_budget = -1;
    stall_mode = stall;
    start_frame(base, lenm1, sof, eof, nopad);
    reg_read(A_CTRL, r);
    check(r[0] == 1'b1, "R2", "busy after start", r, 32'h1);
    check(tx_pad_off == nopad && tx_crc_off == !nopad && r[8] == nopad && r[9] == !nopad,
          "R10", "sideband flags", {tx_pad_off, tx_crc_off, r[9:8]}, {nopad, !nopad, !nopad, nopad});
    wait_irq(seen);
    nbytes = 32'(lenm1) + 1;
    check(seen, "R7", "completion irq", 32'(seen), 32'd1);
    check(mon_n == nbytes, "R3", "byte count", mon_n, nbytes);
    bad_data = 0; bad_mark = 0;
    for (int i = 0; i < nbytes && i < mon_n && i < 256; i++) begin
      if (mon_data[i] != mem_byte(base + 32'(i))) bad_data++;
      if (mon_first[i] != (sof && i == 0)) bad_mark++;
      if (mon_last[i] != (eof && i == nbytes - 1)) bad_mark++;
    end
    check(bad_data == 0, "R3", "byte content mismatches", bad_data, 0);
    check(bad_mark == 0, "R4", "marker mismatches", bad_mark, 0);
    check(hold_viol == 0, "R5", "stall stability violations", hold_viol, 0);
    exp_words = (int'(base[1:0]) + nbytes + 3) / 4;
    check(req_n == exp_words && req_bad == 0, "R6", "word requests",
          req_n + (req_bad << 16), exp_words);
    reg_read(A_CTRL, r);
    check(r[0] == 1'b0 && r[18] == 1'b1 && irq_done, "R7", "ctrl after done",
          {r[31:1], irq_done}, 32'h0004_0001 | (r & 32'hFFFB_FFFE));
    reg_read(A_STAT, r);
    check(r == 32'(nbytes), "R7", "status word", r, 32'(nbytes));
    reg_read(A_CTRL, r);
    reg_write(A_CTRL, r);
    reg_read(A_CTRL, r);
    check(!irq_done && r[18] == 1'b0 && r[0] == 1'b0 && !mem_req_valid, "R8",
          "ack clears status", {r[31:1], irq_done}, r & 32'hFFFB_FFFE);
    stall_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    reg_read(A_CTRL, r);
    check(r == 32'h0002_0000, "R12", "ctrl after reset", r, 32'h0002_0000);
    reg_read(A_STAT, r);
    check(r == 32'h0, "R12", "status after reset", r, 32'h0);
    check(!irq_done && !tx_valid && !mem_req_valid, "R12", "outputs idle",
          {irq_done, tx_valid, mem_req_valid}, 32'h0);

    // R1: register readback while idle
    reg_write(A_BUF, 32'hDEAD_BEE1);
    reg_write(A_LEN, 32'hABCD_1234);
    reg_read(A_BUF, r);
    check(r == 32'hDEAD_BEE1, "R1", "buffer readback", r, 32'hDEAD_BEE1);
    reg_read(A_LEN, r);
    check(r == 32'h0000_1234, "R1", "length readback", r, 32'h0000_1234);

    // R8: control write without go while idle starts nothing
    reg_write(A_CTRL, 32'h0000_000C);
    repeat (3) @(negedge clk);
    reg_read(A_CTRL, r);
    check(r[0] == 1'b0 && !mem_req_valid, "R8", "no start without go", r, r & 32'hFFFF_FFFE);

    // Table of frames
    for (int k = 0; k < NVEC; k++) run_frame(VEC[k]);

    // R1, R11, R9: frame held by a blocked sink, then aborted with zero bytes
    ready_budget = 0;
    start_frame(32'h0000_0800, 16'd40, 1'b1, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    reg_write(A_BUF, 32'h0000_0999);
    reg_write(A_LEN, 32'd3);
    reg_read(A_BUF, r);
    check(r == 32'h0000_0800, "R1", "buffer unchanged while busy", r, 32'h0000_0800);
    reg_read(A_LEN, r);
    check(r == 32'd40, "R1", "length unchanged while busy", r, 32'd40);
    reg_read(A_CTRL, r);
    check(r[16] == 1'b1 && r[17] == 1'b0, "R11", "fifo full flags", r[17:16], 2'b01);
    check(tx_valid && tx_first && tx_data == mem_byte(32'h800), "R5", "stalled first byte",
          {tx_valid, tx_first, tx_data}, {2'b11, mem_byte(32'h800)});
    reg_write(A_CTRL, 32'h0100_0000);
    reg_read(A_CTRL, r);
    check(r[0] == 1'b0 && r[18] == 1'b1 && irq_done && !tx_valid, "R9", "abort ctrl",
          {r[31:1], irq_done}, 32'h0004_0001 | (r & 32'hFFFB_FFFE));
    reg_read(A_STAT, r);
    check(r == 32'h8000_0000, "R9", "abort status zero bytes", r, 32'h8000_0000);
    reg_write(A_CTRL, 32'h0);

    // R9: abort after five accepted bytes
    ready_budget = 5;
    start_frame(32'h0000_0900, 16'd30, 1'b1, 1'b1, 1'b0);
    repeat (60) @(negedge clk);
    check(mon_n == 5, "R5", "bytes accepted under budget", mon_n, 5);
    reg_write(A_CTRL, 32'h0100_0000);
    reg_read(A_STAT, r);
    check(r == 32'h8000_0005, "R9", "abort status partial", r, 32'h8000_0005);
    reg_write(A_CTRL, 32'h0);
    reg_read(A_CTRL, r);
    check(!irq_done && r[18] == 1'b0, "R8", "ack after abort", r, r & 32'hFFFB_FFFF);

    // R9: frame after abort runs correctly
    run_frame(VEC[1]);
    run_frame(VEC[4]);

    // R9: reset bit while idle posts no status
    reg_write(A_CTRL, 32'h0100_0000);
    @(negedge clk);
    reg_read(A_CTRL, r);
    check(r[18] == 1'b0 && r[0] == 1'b0 && !irq_done, "R9", "idle reset posts nothing",
          r, r & 32'hFFFB_FFFE);
    wait_irq(seen);
    check(!seen, "R9", "no irq from idle reset", 32'(seen), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule